// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read/write cache controller for a 24-bit byte address space. A direct-mapped primary array of one-word (4-byte) lines is backed by a small fully associative victim buffer. Lines pushed out of the primary array land in the victim buffer. When two blocks share a primary index and are used in turn, they therefore trade places instead of going back to the next memory level every time.

The CPU presents a request on a valid/ready port and holds it until `cpuReady` is high. A read that hits the primary array completes in the same cycle. A read that misses the primary array but hits the victim buffer completes one cycle later, and the two lines swap in that cycle. A read that misses both goes to next-level memory through a request/ready port. The returned word is installed in the primary array, and the displaced line moves into the victim buffer. Stores are always written through to memory. The cached copy is updated if one exists, and a store never allocates a line.

Each transfer is one 32-bit word, so the two low address bits select nothing. The default index width is reduced for elaboration; the production configuration sets `IDX_W` to 14, which gives an 8-bit tag.

Top module: `vcache`

## Requirements
- R1: The block address is `cpuAddr[23:2]`. The primary index is `cpuAddr[IDX_W+1:2]` and the tag is `cpuAddr[23:IDX_W+2]`. Bits `[1:0]` have no effect on hit, miss or data.
- R2: A read whose tag matches the valid primary line at its index asserts `cpuReady` in the same cycle it is presented. It returns that line's word and makes no memory request.
- R3: A read that misses the primary array but matches a valid victim entry asserts `cpuReady` one cycle after it is presented, with the victim word and no memory request. In that same cycle the victim entry and the primary line at that index exchange places, so the requested block then hits the primary array and the old primary block then hits the victim buffer.
- R4: A read that misses both stores raises `memReqValid` with `memReqWe`=0 and `memReqAddr`=`cpuAddr[23:2]` from the cycle after it is presented. The request is held until `memReady`. In the `memReady` cycle `cpuReady` is asserted with `cpuRdata`=`memRdata`, and the word is installed in the primary array.
- R5: On such a fill, a valid displaced primary line is moved into the victim buffer, where it can later be hit.
- R6: The victim entry chosen for an insertion is the lowest-numbered invalid entry if any exists. Otherwise it is the entry under a round-robin pointer that starts at entry 0 after reset and advances by one, wrapping, on each overwrite of a valid entry.
- R7: A store raises `memReqValid` with `memReqWe`=1, `memReqAddr`=`cpuAddr[23:2]` and `memReqWdata`=`cpuWdata` from the cycle after it is presented, and completes in the `memReady` cycle. It updates the primary or victim copy if one holds the block. It allocates nothing on a miss.
- R8: Reset clears every primary and victim valid bit and the round-robin pointer. With no request, `cpuReady` and `memReqValid` stay low.
- R9: A block is held in at most one place: the primary array or a single victim entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | CPU request present, held until cpuReady |
| cpuReady | output | 1 | Request completes this cycle |
| cpuAddr | input | 24 | CPU byte address |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid while cpuReady on a load |
| memReqValid | output | 1 | Next-level request active |
| memReqWe | output | 1 | 1 = write-through store, 0 = line fetch |
| memReqAddr | output | 22 | Block address of the request |
| memReqWdata | output | 32 | Data for a write-through |
| memReady | input | 1 | Next level completes the request this cycle |
| memRdata | input | 32 | Fetched word, valid with memReady on a fetch |

## Verification
The bench builds the block with `IDX_W`=4 (16 primary lines) and `VB_N`=4. With these values a handful of tags on one index is enough to fill the victim buffer, wrap its round-robin pointer and push out a specific older block. A randomized mix over six tags and four indices then reaches swaps, victim overwrites, victim store hits and store misses within a few hundred requests, with memory latencies of one to three cycles.

// File: rtl/vc_pkg.sv
package vc_pkg;

  typedef enum logic [1:0] {
    ST_LOOKUP,
    ST_SWAP,
    ST_FETCH,
    ST_STORE
  } vcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic doSwap;   // exchange victim hit entry with primary line
    logic doFill;   // install memory word, evict old line to victim
    logic doWrite;  // update whichever copy holds the block
    logic selMem;   // return memory data to the CPU
  } vcStrobe_t;

endpackage

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuValid,
  input  logic      cpuWe,
  input  logic      pHit,
  input  logic      vHit,
  input  logic      memReady,
  output logic      cpuReady,
  output logic      memReqValid,
  output logic      memReqWe,
  output vcStrobe_t stb
);

  vcState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_LOOKUP;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    cpuReady    = 1'b0;
    memReqValid = 1'b0;
    memReqWe    = 1'b0;
    stb         = '0;
    unique case (state)
      ST_LOOKUP: begin
        if (cpuValid) begin
          if (cpuWe)      stateNext = ST_STORE;
          else if (pHit)  cpuReady  = 1'b1;
          else if (vHit)  stateNext = ST_SWAP;
          else            stateNext = ST_FETCH;
        end
      end
      ST_SWAP: begin
        cpuReady   = 1'b1;
        stb.doSwap = 1'b1;
        stateNext  = ST_LOOKUP;
      end
      ST_FETCH: begin
        memReqValid = 1'b1;
        if (memReady) begin
          cpuReady   = 1'b1;
          stb.doFill = 1'b1;
          stb.selMem = 1'b1;
          stateNext  = ST_LOOKUP;
        end
      end
      ST_STORE: begin
        memReqValid = 1'b1;
        memReqWe    = 1'b1;
        if (memReady) begin
          cpuReady    = 1'b1;
          stb.doWrite = 1'b1;
          stateNext   = ST_LOOKUP;
        end
      end
      default: stateNext = ST_LOOKUP;
    endcase
  end

  AST_HIT_NO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOOKUP && cpuValid && !cpuWe && pHit) |-> (cpuReady && !memReqValid)); // R2

  AST_SWAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOOKUP && cpuValid && !cpuWe && !pHit && vHit) |=> (cpuReady && !memReqValid)); // R3

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReady) |=> (memReqValid && $stable(memReqWe))); // R4

  AST_STORE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReady && cpuWe) |-> (memReady && memReqWe)); // R7

endmodule

// File: rtl/vc_datapath.sv
module vc_datapath
  import vc_pkg::*;
#(
  parameter int BLK_W  = 22,
  parameter int IDX_W  = 6,
  parameter int VB_N   = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BLK_W-1:0]  blkAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  vcStrobe_t         stb,
  output logic              pHit,
  output logic              vHit,
  output logic [DATA_W-1:0] rdata
);

  localparam int TAG_W = BLK_W - IDX_W;
  localparam int LINES = 1 << IDX_W;
  localparam int VP_W  = (VB_N > 1) ? $clog2(VB_N) : 1;

  logic [LINES-1:0]  pValid;
  logic [TAG_W-1:0]  pTag  [LINES];
  logic [DATA_W-1:0] pData [LINES];

  logic [VB_N-1:0]   vValid;
  logic [BLK_W-1:0]  vBlk  [VB_N];
  logic [DATA_W-1:0] vData [VB_N];
  logic [VP_W-1:0]   rrPtr;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [VB_N-1:0]   vMatch;
  logic [VP_W-1:0]   vSel;
  logic [VP_W-1:0]   freeIdx;
  logic              freeFound;
  logic [VP_W-1:0]   insIdx;
  logic              evictValid;

  assign idx = blkAddr[IDX_W-1:0];
  assign tag = blkAddr[BLK_W-1:IDX_W];

  assign pHit = pValid[idx] && (pTag[idx] == tag);

  // parallel compare across every victim entry
  generate
    for (genvar g = 0; g < VB_N; g++) begin : gCmp
      assign vMatch[g] = vValid[g] && (vBlk[g] == blkAddr);
    end
  endgenerate

  assign vHit = |vMatch;

  always_comb begin
    vSel = '0;
    for (int i = VB_N - 1; i >= 0; i--) begin
      if (vMatch[i]) vSel = VP_W'(i);
    end
  end

  // lowest invalid entry first, else round-robin
  always_comb begin
    freeIdx = '0;
    for (int i = VB_N - 1; i >= 0; i--) begin
      if (!vValid[i]) freeIdx = VP_W'(i);
    end
  end

  assign freeFound  = ~&vValid;
  assign insIdx     = freeFound ? freeIdx : rrPtr;
  assign evictValid = pValid[idx];

  always_comb begin
    if (stb.selMem)  rdata = memRdata;
    else if (pHit)   rdata = pData[idx];
    else             rdata = vData[vSel];
  end

  // valid bits and replacement pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pValid <= '0;
      vValid <= '0;
      rrPtr  <= '0;
    end else if (stb.doSwap) begin
      vValid[vSel] <= pValid[idx];
      pValid[idx]  <= 1'b1;
    end else if (stb.doFill) begin
      pValid[idx] <= 1'b1;
      if (evictValid) begin
        vValid[insIdx] <= 1'b1;
        if (!freeFound) begin
          if (rrPtr == VP_W'(VB_N - 1)) rrPtr <= '0;
          else                          rrPtr <= rrPtr + 1'b1;
        end
      end
    end
  end

  // tags and data carry no reset
  always_ff @(posedge clk) begin
    if (stb.doSwap) begin
      vBlk[vSel]  <= {pTag[idx], idx};
      vData[vSel] <= pData[idx];
      pTag[idx]   <= tag;
      pData[idx]  <= vData[vSel];
    end else if (stb.doFill) begin
      if (evictValid) begin
        vBlk[insIdx]  <= {pTag[idx], idx};
        vData[insIdx] <= pData[idx];
      end
      pTag[idx]  <= tag;
      pData[idx] <= memRdata;
    end else if (stb.doWrite) begin
      if (pHit)      pData[idx]  <= cpuWdata;
      else if (vHit) vData[vSel] <= cpuWdata;
    end
  end

  AST_SINGLE_HOME: assert property (@(posedge clk) disable iff (!rstN)
    !(pHit && vHit) && ($countones(vMatch) <= 1)); // R9

  AST_SWAP_ON_VHIT: assert property (@(posedge clk) disable iff (!rstN)
    stb.doSwap |-> (vHit && !pHit)); // R3

  AST_FILL_ON_MISS: assert property (@(posedge clk) disable iff (!rstN)
    stb.doFill |-> (!vHit && !pHit)); // R4

  AST_VICTIM_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doFill && evictValid) |=>
      ($countones(vValid) == ($past($countones(vValid)) + ($past(freeFound) ? 1 : 0)))); // R6

endmodule

// File: rtl/vcache.sv
module vcache
  import vc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 6,
  parameter int VB_N   = 4,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpuValid,
  output logic                cpuReady,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic                cpuWe,
  input  logic [DATA_W-1:0]   cpuWdata,
  output logic [DATA_W-1:0]   cpuRdata,
  output logic                memReqValid,
  output logic                memReqWe,
  output logic [ADDR_W-3:0]   memReqAddr,
  output logic [DATA_W-1:0]   memReqWdata,
  input  logic                memReady,
  input  logic [DATA_W-1:0]   memRdata
);

  localparam int BLK_W = ADDR_W - 2;

  vcStrobe_t        stb;
  logic             pHit;
  logic             vHit;
  logic [BLK_W-1:0] blkAddr;
  logic             unusedOffset;

  assign blkAddr      = cpuAddr[ADDR_W-1:2];
  assign unusedOffset = ^cpuAddr[1:0];
  assign memReqAddr   = blkAddr;
  assign memReqWdata  = cpuWdata;

  vc_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuValid   (cpuValid),
    .cpuWe      (cpuWe),
    .pHit       (pHit),
    .vHit       (vHit),
    .memReady   (memReady),
    .cpuReady   (cpuReady),
    .memReqValid(memReqValid),
    .memReqWe   (memReqWe),
    .stb        (stb)
  );

  vc_datapath #(
    .BLK_W (BLK_W),
    .IDX_W (IDX_W),
    .VB_N  (VB_N),
    .DATA_W(DATA_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .blkAddr (blkAddr),
    .cpuWdata(cpuWdata),
    .memRdata(memRdata),
    .stb     (stb),
    .pHit    (pHit),
    .vHit    (vHit),
    .rdata   (cpuRdata)
  );

endmodule

// File: tb/vcache_test.sv
`timescale 1ns/1ps
module vcache_test;

  localparam int ADDR_W = 24;
  localparam int IDX_W  = 4;
  localparam int VB_N   = 4;
  localparam int DATA_W = 32;
  localparam int BLK_W  = ADDR_W - 2;
  localparam int TAG_W  = BLK_W - IDX_W;
  localparam int LINES  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              cpuValid;
  logic              cpuReady;
  logic [ADDR_W-1:0] cpuAddr;
  logic              cpuWe;
  logic [DATA_W-1:0] cpuWdata;
  logic [DATA_W-1:0] cpuRdata;
  logic              memReqValid;
  logic              memReqWe;
  logic [BLK_W-1:0]  memReqAddr;
  logic [DATA_W-1:0] memReqWdata;
  logic              memReady;
  logic [DATA_W-1:0] memRdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vcache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .VB_N(VB_N), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuReady(cpuReady),
    .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .memReqValid(memReqValid), .memReqWe(memReqWe), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memReady(memReady), .memRdata(memRdata)
  );

  // behavioural reference state
  bit               mPV [LINES];
  logic [TAG_W-1:0] mPT [LINES];
  logic [31:0]      mPD [LINES];
  bit               mVV [VB_N];
  logic [BLK_W-1:0] mVB [VB_N];
  logic [31:0]      mVD [VB_N];
  int               mRr;
  logic [31:0]      memStore [bit [BLK_W-1:0]];

  function automatic logic [31:0] memVal(input logic [BLK_W-1:0] b);
    if (memStore.exists(b)) return memStore[b];
    return {10'h2D3, b};
  endfunction

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic access(input bit we, input logic [ADDR_W-1:0] a,
                        input logic [31:0] wd, input int lat, input string lbl);
    logic [BLK_W-1:0] blk;
    int idx;
    logic [TAG_W-1:0] tg;
    bit ph, vh, done;
    int vk;
    string msg;
    logic [31:0] expData;
    bit expReady, expReq;
    blk = a[ADDR_W-1:2];
    idx = int'(blk[IDX_W-1:0]);
    tg  = blk[BLK_W-1:IDX_W];
    ph  = mPV[idx] && (mPT[idx] == tg);
    vh  = 0; vk = 0;
    for (int i = VB_N - 1; i >= 0; i--) if (mVV[i] && mVB[i] == blk) begin vh = 1; vk = i; end
    if (we)      msg = {"R7 ", lbl};
    else if (ph) msg = {"R2 ", lbl};
    else if (vh) msg = {"R3 ", lbl};
    else         msg = {"R4 ", lbl};
    expData = ph ? mPD[idx] : (vh ? mVD[vk] : memVal(blk));
    done = 0;
    for (int cyc = 0; !done && cyc < 40; cyc++) begin
      @(negedge clk);
      cpuValid = 1; cpuAddr = a; cpuWe = we; cpuWdata = wd;
      memReady = (cyc == lat) && (we || (!ph && !vh));
      memRdata = memVal(blk);
      #1;
      if (!we && ph)      begin expReady = 1;            expReq = 0;          end
      else if (!we && vh) begin expReady = (cyc == 1);   expReq = 0;          end
      else                begin expReady = (cyc == lat); expReq = (cyc >= 1); end
      checkEq({msg, " ready"}, 32'(cpuReady), 32'(expReady));
      checkEq({msg, " memReqValid"}, 32'(memReqValid), 32'(expReq));
      if (expReq) begin
        checkEq({msg, " memReqAddr"}, 32'(memReqAddr), 32'(blk));
        checkEq({msg, " memReqWe"}, 32'(memReqWe), 32'(we));
        if (we) checkEq({msg, " memReqWdata"}, memReqWdata, wd);
      end
      if (expReady && !we) checkEq({msg, " rdata"}, cpuRdata, expData);
      done = expReady;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL %s request never completed", msg);
    end
    @(posedge clk);
    #1 cpuValid = 0; memReady = 0;
    // reference update
    if (we) begin
      memStore[blk] = wd;
      if (ph) mPD[idx] = wd;
      else if (vh) mVD[vk] = wd;
    end else if (!ph && vh) begin
      logic [31:0] tD; bit tV; logic [BLK_W-1:0] tB;
      tV = mPV[idx]; tB = {mPT[idx], blk[IDX_W-1:0]}; tD = mPD[idx];
      mPV[idx] = 1; mPT[idx] = tg; mPD[idx] = mVD[vk];
      mVV[vk] = tV; mVB[vk] = tB; mVD[vk] = tD;
    end else if (!ph) begin
      if (mPV[idx]) begin
        int slot; bit fr;
        fr = 0; slot = 0;
        for (int i = VB_N - 1; i >= 0; i--) if (!mVV[i]) begin fr = 1; slot = i; end
        if (!fr) begin slot = mRr; mRr = (mRr + 1) % VB_N; end
        mVV[slot] = 1; mVB[slot] = {mPT[idx], blk[IDX_W-1:0]}; mVD[slot] = mPD[idx];
      end
      mPV[idx] = 1; mPT[idx] = tg; mPD[idx] = memVal(blk);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mkAddr(input int t, input int ix, input int off);
    return {TAG_W'(t), IDX_W'(ix), 2'(off)};
  endfunction

  task automatic expectKind(input string tag, input logic [ADDR_W-1:0] a, input int kind);
    // kind: 0 primary hit, 1 victim hit, 2 miss
    logic [BLK_W-1:0] blk;
    int idx, k;
    blk = a[ADDR_W-1:2];
    idx = int'(blk[IDX_W-1:0]);
    k = 2;
    for (int i = 0; i < VB_N; i++) if (mVV[i] && mVB[i] == blk) k = 1;
    if (mPV[idx] && mPT[idx] == blk[BLK_W-1:IDX_W]) k = 0;
    checkEq({tag, " reference path"}, 32'(k), 32'(kind));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    for (int i = 0; i < LINES; i++) begin mPV[i] = 0; mPT[i] = '0; mPD[i] = '0; end
    for (int i = 0; i < VB_N; i++) begin mVV[i] = 0; mVB[i] = '0; mVD[i] = '0; end
    mRr = 0;
    rstN = 0; cpuValid = 0; cpuAddr = '0; cpuWe = 0; cpuWdata = '0;
    memReady = 0; memRdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    checkEq("R8 reset ready", 32'(cpuReady), 0);
    checkEq("R8 reset memReqValid", 32'(memReqValid), 0);
    rstN = 1;
    @(negedge clk); #1;
    checkEq("R8 idle ready", 32'(cpuReady), 0);
    checkEq("R8 idle memReqValid", 32'(memReqValid), 0);

    // R8: cold cache misses
    expectKind("R8", mkAddr(1, 3, 0), 2);
    access(0, mkAddr(1, 3, 0), 0, 2, "R8 cold miss");
    // R2 / R1
    expectKind("R2", mkAddr(1, 3, 0), 0);
    access(0, mkAddr(1, 3, 0), 0, 1, "hit");
    expectKind("R1", mkAddr(1, 3, 3), 0);
    access(0, mkAddr(1, 3, 3), 0, 1, "R1 offset ignored");
    // R5: conflicting block displaces into victim
    access(0, mkAddr(2, 3, 1), 0, 1, "R5 conflict fill");
    expectKind("R5", mkAddr(1, 3, 0), 1);
    access(0, mkAddr(1, 3, 0), 0, 1, "R5 R3 swap back");
    expectKind("R3", mkAddr(1, 3, 0), 0);
    expectKind("R3", mkAddr(2, 3, 0), 1);
    access(0, mkAddr(1, 3, 2), 0, 1, "R3 swapped block in primary");
    access(0, mkAddr(2, 3, 0), 0, 1, "R3 old primary in victim");
    // R7: write-through into primary and victim copies, and no allocate
    access(1, mkAddr(2, 3, 0), 32'hCAFE0001, 2, "primary store");
    access(0, mkAddr(2, 3, 0), 0, 1, "R7 read after primary store");
    access(1, mkAddr(1, 3, 0), 32'hCAFE0002, 1, "victim store");
    access(0, mkAddr(1, 3, 0), 0, 1, "R7 read after victim store");
    access(1, mkAddr(9, 7, 0), 32'hCAFE0003, 3, "store miss");
    expectKind("R7", mkAddr(9, 7, 0), 2);
    access(0, mkAddr(9, 7, 0), 0, 2, "R7 no allocate then fetch");
    // R6: fill victim buffer and wrap the pointer on index 0
    for (int t = 10; t < 16; t++) access(0, mkAddr(t, 0, 0), 0, 1, "R6 fill sequence");
    expectKind("R6", mkAddr(10, 0, 0), 2);
    expectKind("R6", mkAddr(11, 0, 0), 1);
    access(0, mkAddr(11, 0, 0), 0, 1, "R6 survivor");
    access(0, mkAddr(10, 0, 0), 0, 2, "R6 overwritten");

    // R9 and mixed traffic
    lcg = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      int t, ix, lat;
      bit w;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      t   = int'(lcg[31:29]) % 6;
      ix  = int'(lcg[27:26]);
      w   = (lcg[25:24] == 2'b00);
      lat = 1 + int'(lcg[23:22]) % 3;
      access(w, mkAddr(t, ix, int'(lcg[21:20])), lcg ^ 32'h5A5A_0000, lat, "R9 mixed");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule